// File: doc/BRIEF.md
# External Bus Ownership Arbiter

This block decides who drives a shared external memory bus: the on-chip bus controller or an external master. The external master raises a request line. The arbiter lets any access already in progress finish. It then hands the bus over by driving an active-low grant, and it turns off the output-enable of the address, chip-select, strobe and row/column-strobe pads so that those pins float. When the external master drops its request, the arbiter takes the bus back at once. All of these state changes happen on the system clock.

A DRAM refresh request may arrive while the bus is handed out. The arbiter stores it and negates the grant to ask for the bus back. The pads stay floating until the external master lets go of its request. On the edge after that, the arbiter starts the refresh with a one-cycle start pulse and enables the pads again.

CPU requests carry a 2-bit space code. Accesses to on-chip data RAM and to on-chip ROM/flash never stall. Accesses to on-chip I/O and to external memory stall whenever the arbiter cannot offer the bus to them.

Top module: `xbus_arbiter`

## Requirements
- R1: While reset is applied and until the first arbitration decision, `bus_grant_n_o` is 1, `pad_oe_o` is 1 and `rfsh_start_o` is 0.
- R2: While `acc_busy_i` is 1, an asserted `ext_req_i` does not pull `bus_grant_n_o` low. At the first clock edge that samples `acc_busy_i` low with `ext_req_i` high and no refresh pending, `bus_grant_n_o` goes to 0.
- R3: `pad_oe_o` falls on the same clock edge as `bus_grant_n_o`, and it stays 0 for as long as the external master holds the bus (grant low, or the bus being reclaimed).
- R4: While the bus is handed out, the first edge that samples `ext_req_i` low returns `bus_grant_n_o` and `pad_oe_o` to 1.
- R5: A refresh pending while the bus is handed out raises `bus_grant_n_o` on the next edge, with `pad_oe_o` still 0. `rfsh_start_o` stays 0 until `ext_req_i` is sampled low. On that edge `rfsh_start_o` and `pad_oe_o` both become 1.
- R6: A one-cycle pulse on `rfsh_req_i` is kept pending until the refresh is started, however long the external master holds on.
- R7: A CPU request with space code 0 (data RAM) or 1 (ROM/flash) never asserts its stall output.
- R8: A CPU request with space code 2 (I/O) or 3 (external memory) asserts its stall output whenever the arbiter is not in the owned-idle state or `ext_req_i` is 1. It is released while the arbiter owns the bus with no refresh running and `ext_req_i` is 0.
- R9: After `rfsh_done_i` ends a refresh, `ext_req_i` is sampled again. If it is still high and no access is busy, the bus is handed out again on the following edge.
- R10: When the arbiter owns an idle bus, a pending refresh takes priority over an external request.
- R11: `rfsh_start_o` is high for exactly one clock cycle for each refresh started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| arst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_req_i | input | 1 | Bus request from the external master |
| acc_busy_i | input | 1 | High while an on-chip bus access is still running |
| rfsh_req_i | input | 1 | Refresh request pulse from the DRAM timer |
| rfsh_done_i | input | 1 | Refresh engine reports the refresh finished |
| cpu_req_i | input | NPORT | One request valid bit per CPU access port |
| cpu_space_i | input | 2*NPORT | Space code per port: 0 data RAM, 1 ROM/flash, 2 I/O, 3 external |
| bus_grant_n_o | output | 1 | 0 hands the bus to the external master |
| pad_oe_o | output | 1 | Enable for address, select, strobe and row/column-strobe pads |
| rfsh_start_o | output | 1 | One-cycle pulse that starts a refresh |
| cpu_stall_o | output | NPORT | Stall per CPU access port |

## Verification
The bench builds the block with NPORT set to 3 and drives the ports with space codes 0, 2 and 3. This puts a port that never stalls next to two ports that must stall, so that every grant, reclaim and refresh phase can be checked against both classes of access. The reset synchronizer keeps its default depth of two stages. Because of that the bench waits for the release before it checks the first arbitration decision.

// File: rtl/xba_pkg.sv
package xba_pkg;
  typedef enum logic [1:0] {
    ST_OWN      = 2'd0,
    ST_REFRESH  = 2'd1,
    ST_RELEASED = 2'd2,
    ST_RECLAIM  = 2'd3
  } own_state_e;

  localparam int SPACE_W = 2;

  typedef enum logic [SPACE_W-1:0] {
    SP_DATA_RAM = 2'd0,
    SP_ROM      = 2'd1,
    SP_IO       = 2'd2,
    SP_EXT_MEM  = 2'd3
  } space_e;

  // Bit 1 of the space code marks the spaces that need the external bus path.
  function automatic logic space_needs_bus(input logic [SPACE_W-1:0] sp);
    return sp[1];
  endfunction
endpackage

// File: rtl/xba_rst_sync.sv
module xba_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/xba_rfsh_latch.sv
module xba_rfsh_latch (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = set_i | clr_i;
    pend_d  = set_i | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R6: the state machine only consumes a refresh that was stored
  assert_clear_needs_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_i |-> pend_q);
  // R6: a stored request survives until it is consumed
  assert_pending_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/xba_own_fsm.sv
module xba_own_fsm
  import xba_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ext_req_i,
  input  logic acc_busy_i,
  input  logic rfsh_pend_i,
  input  logic rfsh_done_i,
  output logic rfsh_clr_o,
  output logic grant_n_o,
  output logic pad_oe_o,
  output logic rfsh_start_o,
  output logic bus_free_o
);
  own_state_e state_q, state_d;
  logic grant_n_q, grant_n_d;
  logic oe_q, oe_d;
  logic start_q, start_d;
  logic state_en;

  always_comb begin
    state_d    = state_q;
    grant_n_d  = grant_n_q;
    oe_d       = oe_q;
    start_d    = 1'b0;
    rfsh_clr_o = 1'b0;
    unique case (state_q)
      ST_OWN: begin
        if (!acc_busy_i) begin
          if (rfsh_pend_i) begin
            state_d    = ST_REFRESH;
            start_d    = 1'b1;
            rfsh_clr_o = 1'b1;
          end else if (ext_req_i) begin
            state_d   = ST_RELEASED;
            grant_n_d = 1'b0;
            oe_d      = 1'b0;
          end
        end
      end
      ST_REFRESH: begin
        if (rfsh_done_i) state_d = ST_OWN;
      end
      ST_RELEASED: begin
        if (!ext_req_i) begin
          state_d   = ST_OWN;
          grant_n_d = 1'b1;
          oe_d      = 1'b1;
        end else if (rfsh_pend_i) begin
          state_d   = ST_RECLAIM;
          grant_n_d = 1'b1;
        end
      end
      ST_RECLAIM: begin
        if (!ext_req_i) begin
          state_d    = ST_REFRESH;
          oe_d       = 1'b1;
          start_d    = 1'b1;
          rfsh_clr_o = 1'b1;
        end
      end
      default: state_d = ST_OWN;
    endcase
    state_en = (state_d != state_q) | start_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q   <= ST_OWN;
      grant_n_q <= 1'b1;
      oe_q      <= 1'b1;
      start_q   <= 1'b0;
    end else begin
      if (state_en) begin
        state_q   <= state_d;
        grant_n_q <= grant_n_d;
        oe_q      <= oe_d;
      end
      start_q <= start_d;
    end
  end

  assign grant_n_o    = grant_n_q;
  assign pad_oe_o     = oe_q;
  assign rfsh_start_o = start_q;
  assign bus_free_o   = (state_q == ST_OWN);

  // R2: the hand-over edge only follows a sampled idle bus with a live request
  assert_grant_after_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(grant_n_q) |-> $past(!acc_busy_i && ext_req_i));
  // R3: pads never drive while the external master has the bus
  assert_float_when_out_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !grant_n_q |-> !oe_q);
  // R4: a dropped request while handed out brings the bus straight back
  assert_return_on_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(state_q) == ST_RELEASED && !$past(ext_req_i)) |-> (grant_n_q && oe_q));
  // R5: refresh starts only on an owned, driven bus
  assert_start_owned_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    start_q |-> (grant_n_q && oe_q));
  // R11: the start is a single-cycle pulse
  assert_start_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    start_q |=> !start_q);
endmodule

// File: rtl/xba_stall.sv
module xba_stall
  import xba_pkg::*;
#(
  parameter int NPORT = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     bus_open_i,
  input  logic [NPORT-1:0]         req_i,
  input  logic [NPORT*SPACE_W-1:0] space_i,
  output logic [NPORT-1:0]         stall_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [SPACE_W-1:0] sp;
    assign sp         = space_i[p*SPACE_W +: SPACE_W];
    assign stall_o[p] = req_i[p] & space_needs_bus(sp) & ~bus_open_i;

    // R7: on-chip memory accesses are never held back
    assert_fast_free_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (sp == SP_DATA_RAM || sp == SP_ROM) |-> !stall_o[p]);
  end
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
  import xba_pkg::*;
#(
  parameter int NPORT     = 3,
  parameter int RST_STAGE = 2
) (
  input  logic                     clk_i,
  input  logic                     arst_n_i,
  input  logic                     ext_req_i,
  input  logic                     acc_busy_i,
  input  logic                     rfsh_req_i,
  input  logic                     rfsh_done_i,
  input  logic [NPORT-1:0]         cpu_req_i,
  input  logic [NPORT*SPACE_W-1:0] cpu_space_i,
  output logic                     bus_grant_n_o,
  output logic                     pad_oe_o,
  output logic                     rfsh_start_o,
  output logic [NPORT-1:0]         cpu_stall_o
);
  logic rst_n, pend, clr, bus_free, bus_open;

  xba_rst_sync #(.STAGES(RST_STAGE)) i_rst_sync (
    .clk_i(clk_i), .arst_n_i(arst_n_i), .rst_n_o(rst_n));

  xba_rfsh_latch i_rfsh_latch (
    .clk_i(clk_i), .rst_n_i(rst_n), .set_i(rfsh_req_i), .clr_i(clr), .pend_o(pend));

  xba_own_fsm i_own_fsm (
    .clk_i(clk_i), .rst_n_i(rst_n), .ext_req_i(ext_req_i), .acc_busy_i(acc_busy_i),
    .rfsh_pend_i(pend), .rfsh_done_i(rfsh_done_i), .rfsh_clr_o(clr),
    .grant_n_o(bus_grant_n_o), .pad_oe_o(pad_oe_o), .rfsh_start_o(rfsh_start_o),
    .bus_free_o(bus_free));

  assign bus_open = bus_free & ~ext_req_i;

  xba_stall #(.NPORT(NPORT)) i_stall (
    .clk_i(clk_i), .rst_n_i(rst_n), .bus_open_i(bus_open), .req_i(cpu_req_i),
    .space_i(cpu_space_i), .stall_o(cpu_stall_o));

  // R8: a held-off bus-path access stalls whenever the bus is handed out
  assert_stall_when_out_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!bus_grant_n_o && cpu_req_i[NPORT-1] && space_needs_bus(cpu_space_i[NPORT*SPACE_W-1 -: SPACE_W]))
      |-> cpu_stall_o[NPORT-1]);
endmodule

// File: tb/test_xbus_arbiter.sv
`timescale 1ns/1ps
module test_xbus_arbiter;
  localparam int NPORT = 3;
  logic clk = 1'b0;
  logic arst_n, ext_req, busy, rreq, rdone;
  logic [NPORT-1:0] cpu_req;
  logic [NPORT*2-1:0] cpu_space;
  logic grant_n, oe, rstart;
  logic [NPORT-1:0] stall;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  xbus_arbiter #(.NPORT(NPORT)) i_xbus_arbiter (
    .clk_i(clk), .arst_n_i(arst_n), .ext_req_i(ext_req), .acc_busy_i(busy),
    .rfsh_req_i(rreq), .rfsh_done_i(rdone), .cpu_req_i(cpu_req), .cpu_space_i(cpu_space),
    .bus_grant_n_o(grant_n), .pad_oe_o(oe), .rfsh_start_o(rstart), .cpu_stall_o(stall));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // ports: 0 data RAM, 1 I/O, 2 external memory -> blocked stall pattern 3'b110
  task automatic t_reset();
    arst_n = 1'b0; ext_req = 0; busy = 0; rreq = 0; rdone = 0;
    cpu_req = '1; cpu_space = {2'd3, 2'd2, 2'd0};
    repeat (3) step();
    chk("R1 grant", grant_n, 1); chk("R1 oe", oe, 1); chk("R1 start", rstart, 0);
    arst_n = 1'b1;
    repeat (3) step();
    chk("R1 grant after release", grant_n, 1); chk("R8 open stall", stall, 3'b000);
  endtask

  task automatic t_busy_hold();
    busy = 1; ext_req = 1;
    step(); chk("R2 busy grant", grant_n, 1); chk("R8 pending stall", stall, 3'b110);
    step(); chk("R2 busy grant 2", grant_n, 1); chk("R3 oe busy", oe, 1);
    busy = 0;
    step(); chk("R2 grant low", grant_n, 0); chk("R3 oe low", oe, 0);
    chk("R7 R8 released stall", stall, 3'b110);
  endtask

  task automatic t_return();
    ext_req = 0;
    step(); chk("R4 grant back", grant_n, 1); chk("R4 oe back", oe, 1);
    chk("R8 reopened", stall, 3'b000);
  endtask

  task automatic t_refresh_reclaim();
    ext_req = 1;
    step(); chk("R2 released", grant_n, 0);
    rreq = 1; step(); rreq = 0;
    step(); chk("R5 reclaim grant", grant_n, 1); chk("R5 oe float", oe, 0);
    chk("R5 no start", rstart, 0);
    repeat (4) step();
    chk("R6 still waiting", rstart, 0); chk("R3 oe reclaim", oe, 0);
    ext_req = 0;
    step(); chk("R5 start", rstart, 1); chk("R5 oe on", oe, 1);
    chk("R8 refresh stall", stall, 3'b110);
    ext_req = 1;
    step(); chk("R11 pulse", rstart, 0); chk("R9 hold in refresh", grant_n, 1);
    rdone = 1; step(); rdone = 0;
    chk("R9 owned", grant_n, 1);
    step(); chk("R9 rerelease", grant_n, 0); chk("R3 oe rerelease", oe, 0);
    ext_req = 0; step(); chk("R4 back", grant_n, 1);
  endtask

  task automatic t_owned_priority();
    busy = 1; ext_req = 1; rreq = 1;
    step(); rreq = 0;
    step(); chk("R2 busy hold", grant_n, 1); chk("R10 no start busy", rstart, 0);
    busy = 0;
    step(); chk("R10 refresh first", rstart, 1); chk("R10 grant kept", grant_n, 1);
    step(); chk("R11 single", rstart, 0);
    rdone = 1; step(); rdone = 0;
    step(); chk("R9 release after", grant_n, 0);
    ext_req = 0; step(); chk("R4 final", grant_n, 1);
  endtask

  initial begin
    t_reset();
    t_busy_hold();
    t_return();
    t_refresh_reclaim();
    t_owned_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule